// File: doc/BRIEF.md
# Adaptive Charge-Pump Gain Selector

This block decides, once per system clock, whether an inductorless LED charge pump runs in pass mode (gain 1x) or in boost mode (gain 3/2x), and whether the pump runs at all. Each current sink of the two display banks has an analog comparator. The comparator raises a digital flag when the voltage across its sink falls below the regulation threshold. The block takes these eight flags, along with the bank enables and the per-pin sense enables held in a control register. The first bank has five sinks and the second has three. The indicator bank has no flag: it only keeps the pump powered.

The flags come from an asynchronous analog domain, so each one passes through a two-stage synchronizer. A flag takes part only after it has read high on two consecutive synchronized clocks. The block combines the flags of active, sensed pins with a logical OR, so the pin with the highest LED forward voltage sets the gain. Any qualified flag moves the pump from 1x to 3/2x. The pump returns to 1x only after every monitored flag has stayed clear for a programmable number of clocks, which prevents chattering near the threshold. A thermal-trip input and the all-banks-off condition both stop the pump and drop the gain to 1x.

Top module: `pump_gain_ctrl`

## Requirements
- R1: While reset is asserted and right after its release, `pumpOn` and `gainBoost` are 0.
- R2: One clock after any of `enBankA`, `enBankB` or `enBankC` becomes 1, `pumpOn` is 1 with `gainBoost` 0. One clock after all three are 0, `pumpOn` and `gainBoost` are both 0. With only `enBankC` set, the pump runs and every flag is ignored.
- R3: In pass mode, a monitored flag held high makes `gainBoost` rise after the fourth rising clock edge, counted from the first edge that samples the flag high. The path is two synchronizer stages, one qualification stage and the mode register.
- R4: A flag that is high for only one clock edge never changes `gainBoost`.
- R5: The flags of a disabled bank are ignored. Flags of the three-sink bank (`senseLowB`) have no effect while `enBankB` is 0, and flags of the five-sink bank (`senseLowA`) have no effect while `enBankA` is 0.
- R6: Bit 4 of `senseLowA` is monitored only when `enSenseLastA` is 1. Bit 2 of `senseLowB` is monitored only when `enLastB` is 1. `driveLastB` equals `enBankB` AND `enLastB`.
- R7: With all enables set, a flag on any single one of the eight pins is enough to select 3/2x.
- R8: Boost mode returns to 1x only after the masked flags have read clear for `holdCount` consecutive clocks. A qualified flag during the wait restarts the count. A `holdCount` of 0 behaves as 1.
- R9: One clock after `thermalTrip` rises, `pumpOn` and `gainBoost` are 0, and they stay 0 while it is high. One clock after it falls, the pump restarts in 1x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| senseLowA | input | 5 | Headroom-low flags of the five-sink bank (bit 4 = separately sensed last pin) |
| senseLowB | input | 3 | Headroom-low flags of the three-sink bank (bit 2 = switchable last pin) |
| enBankA | input | 1 | Enable of the five-sink bank |
| enBankB | input | 1 | Enable of the three-sink bank |
| enBankC | input | 1 | Enable of the indicator sink (never monitored) |
| enSenseLastA | input | 1 | Sense enable for bit 4 of the five-sink bank |
| enLastB | input | 1 | Driver and sense enable for bit 2 of the three-sink bank |
| holdCount | input | 8 | Clear clocks required before returning to 1x |
| thermalTrip | input | 1 | Over-temperature indication; stops the pump while high |
| gainBoost | output | 1 | 1 = gain 3/2x, 0 = gain 1x |
| pumpOn | output | 1 | Charge pump enable |
| driveLastB | output | 1 | Driver enable for the switchable last sink of the three-sink bank |

## Verification
A stuck or stale synchronizer stage shows up at `gainBoost` as a rise one clock early or late against the fixed four-edge latency, or as a reaction to a one-clock glitch. A wrong mask either boosts on a disabled pin or ignores an enabled one within four clocks of the flag. A hold counter that fails to restart or to expire moves the 1x return away from exactly `holdCount` plus two clocks after the flag clears. A mode register that misses a thermal trip or an all-off condition leaves `pumpOn` high one clock after the cause.

// File: rtl/pump_gain_pkg.sv
package pump_gain_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_PASS  = 2'd1,
    ST_BOOST = 2'd2
  } gainState_t;

  // Strobes from the mode control to the hold counter in the sense path.
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } holdCtl_t;

endpackage

// File: rtl/pump_sense_path.sv
module pump_sense_path
  import pump_gain_pkg::*;
#(
  parameter int NUM_A  = 5,
  parameter int NUM_B  = 3,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_A-1:0]  senseLowA,
  input  logic [NUM_B-1:0]  senseLowB,
  input  logic              enBankA,
  input  logic              enBankB,
  input  logic              enSenseLastA,
  input  logic              enLastB,
  input  logic [HOLD_W-1:0] holdCount,
  input  holdCtl_t          holdCtl,
  output logic              anyLow,
  output logic              holdDone
);

  localparam int NUM_PINS = NUM_A + NUM_B;

  logic [NUM_PINS-1:0] rawFlags;
  logic [NUM_PINS-1:0] metaStage;
  logic [NUM_PINS-1:0] syncStage;
  logic [NUM_PINS-1:0] prevStage;
  logic [NUM_PINS-1:0] qualified;
  logic [NUM_PINS-1:0] pinMask;
  logic [HOLD_W-1:0]   holdCnt;
  logic [HOLD_W:0]     cntPlusOne;

  assign rawFlags = {senseLowB, senseLowA};

  // Two-stage synchronizer followed by a one-clock history stage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaStage <= '0;
      syncStage <= '0;
      prevStage <= '0;
    end else begin
      metaStage <= rawFlags;
      syncStage <= metaStage;
      prevStage <= syncStage;
    end
  end

  // A flag counts only after two consecutive synchronized highs.
  assign qualified = syncStage & prevStage;

  // Per-pin participation mask: only pins of enabled banks, and the
  // last pin of each bank only when its own sense enable is set.
  generate
    for (genvar gi = 0; gi < NUM_A; gi++) begin : g_maskA
      if (gi == NUM_A - 1) begin : g_last
        assign pinMask[gi] = enBankA & enSenseLastA;
      end else begin : g_plain
        assign pinMask[gi] = enBankA;
      end
    end
    for (genvar gj = 0; gj < NUM_B; gj++) begin : g_maskB
      if (gj == NUM_B - 1) begin : g_last
        assign pinMask[NUM_A+gj] = enBankB & enLastB;
      end else begin : g_plain
        assign pinMask[NUM_A+gj] = enBankB;
      end
    end
  endgenerate

  // Worst-case pin decides: any qualified, masked flag.
  assign anyLow = |(qualified & pinMask);

  // Hold counter for the return to 1x.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (holdCtl.cntClr) begin
      holdCnt <= '0;
    end else if (holdCtl.cntInc) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign cntPlusOne = {1'b0, holdCnt} + {{HOLD_W{1'b0}}, 1'b1};
  assign holdDone   = cntPlusOne >= {1'b0, holdCount};

  // R4: a qualified flag must have been seen by the first stage on the
  // two preceding clocks.
  generate
    for (genvar gk = 0; gk < NUM_PINS; gk++) begin : g_chk
      p_qual_history_r4: assert property (@(posedge clk) disable iff (!rstN)
        qualified[gk] |-> ($past(metaStage[gk]) && $past(metaStage[gk], 2)));
    end
  endgenerate

  // R8: clear and count are never requested together.
  p_hold_strobes_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(holdCtl.cntClr && holdCtl.cntInc));

endmodule

// File: rtl/pump_gain_fsm.sv
module pump_gain_fsm
  import pump_gain_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enBankA,
  input  logic     enBankB,
  input  logic     enBankC,
  input  logic     thermalTrip,
  input  logic     anyLow,
  input  logic     holdDone,
  output holdCtl_t holdCtl,
  output logic     gainBoost,
  output logic     pumpOn
);

  gainState_t state;
  gainState_t nextState;
  logic       anyEnable;

  assign anyEnable = enBankA | enBankB | enBankC;

  always_comb begin
    nextState      = state;
    holdCtl.cntClr = 1'b1;
    holdCtl.cntInc = 1'b0;
    if (thermalTrip || !anyEnable) begin
      nextState = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:  nextState = ST_PASS;
        ST_PASS: if (anyLow) nextState = ST_BOOST;
        ST_BOOST: begin
          if (!anyLow) begin
            if (holdDone) begin
              nextState = ST_PASS;
            end else begin
              holdCtl.cntClr = 1'b0;
              holdCtl.cntInc = 1'b1;
            end
          end
        end
        default: nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  assign gainBoost = (state == ST_BOOST);
  assign pumpOn    = (state != ST_OFF);

  // R9: a thermal trip stops the pump and drops the gain on the next clock.
  p_thermal_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    thermalTrip |=> (!pumpOn && !gainBoost));

  // R2: all banks off shuts the pump down on the next clock.
  p_shutdown_r2: assert property (@(posedge clk) disable iff (!rstN)
    !anyEnable |=> !pumpOn);

  // R3: pass mode never moves to boost without a qualified flag.
  p_boost_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASS && !anyLow) |=> !gainBoost);

  // R8: a qualified flag in boost mode keeps boost mode.
  p_hold_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (gainBoost && anyLow && anyEnable && !thermalTrip) |=> gainBoost);

endmodule

// File: rtl/pump_gain_ctrl.sv
module pump_gain_ctrl
  import pump_gain_pkg::*;
#(
  parameter int NUM_A  = 5,
  parameter int NUM_B  = 3,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_A-1:0]  senseLowA,
  input  logic [NUM_B-1:0]  senseLowB,
  input  logic              enBankA,
  input  logic              enBankB,
  input  logic              enBankC,
  input  logic              enSenseLastA,
  input  logic              enLastB,
  input  logic [HOLD_W-1:0] holdCount,
  input  logic              thermalTrip,
  output logic              gainBoost,
  output logic              pumpOn,
  output logic              driveLastB
);

  holdCtl_t holdCtl;
  logic     anyLow;
  logic     holdDone;

  pump_sense_path #(
    .NUM_A (NUM_A),
    .NUM_B (NUM_B),
    .HOLD_W(HOLD_W)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .senseLowA   (senseLowA),
    .senseLowB   (senseLowB),
    .enBankA     (enBankA),
    .enBankB     (enBankB),
    .enSenseLastA(enSenseLastA),
    .enLastB     (enLastB),
    .holdCount   (holdCount),
    .holdCtl     (holdCtl),
    .anyLow      (anyLow),
    .holdDone    (holdDone)
  );

  pump_gain_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .enBankA    (enBankA),
    .enBankB    (enBankB),
    .enBankC    (enBankC),
    .thermalTrip(thermalTrip),
    .anyLow     (anyLow),
    .holdDone   (holdDone),
    .holdCtl    (holdCtl),
    .gainBoost  (gainBoost),
    .pumpOn     (pumpOn)
  );

  // The switchable sink's driver follows its bank and its own enable.
  assign driveLastB = enBankB & enLastB;

endmodule

// File: tb/tb_pump_gain_ctrl.sv
module tb_pump_gain_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 5;

  logic       clk = 1'b0;
  logic       rstN;
  logic [4:0] senseLowA;
  logic [2:0] senseLowB;
  logic       enBankA, enBankB, enBankC, enSenseLastA, enLastB;
  logic [7:0] holdCount;
  logic       thermalTrip;
  logic       gainBoost, pumpOn, driveLastB;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pump_gain_ctrl dut (
    .clk(clk), .rstN(rstN), .senseLowA(senseLowA), .senseLowB(senseLowB),
    .enBankA(enBankA), .enBankB(enBankB), .enBankC(enBankC),
    .enSenseLastA(enSenseLastA), .enLastB(enLastB), .holdCount(holdCount),
    .thermalTrip(thermalTrip), .gainBoost(gainBoost), .pumpOn(pumpOn),
    .driveLastB(driveLastB)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // n rising edges, then return at the following falling edge
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPin(input int idx, input logic v);
    if (idx < 5) senseLowA[idx] = v;
    else         senseLowB[idx-5] = v;
  endtask

  task automatic allOn();
    enBankA = 1; enBankB = 1; enBankC = 0; enSenseLastA = 1; enLastB = 1;
  endtask

  task automatic t_reset();
    rstN = 0; senseLowA = '0; senseLowB = '0; thermalTrip = 0;
    enBankA = 0; enBankB = 0; enBankC = 0; enSenseLastA = 0; enLastB = 0;
    holdCount = 8'(HOLD);
    tick(3);
    check("R1 pumpOn in reset", pumpOn, 1'b0);
    check("R1 gainBoost in reset", gainBoost, 1'b0);
    rstN = 1;
    tick(2);
    check("R1 pumpOn after reset", pumpOn, 1'b0);
    check("R1 gainBoost after reset", gainBoost, 1'b0);
  endtask

  task automatic t_enable();
    enBankA = 1;
    tick(1);
    check("R2 pump on after enable", pumpOn, 1'b1);
    check("R2 starts at 1x", gainBoost, 1'b0);
  endtask

  task automatic t_boost_and_hold();
    senseLowA[0] = 1;
    tick(3);
    check("R3 not yet boosted after 3 edges", gainBoost, 1'b0);
    tick(1);
    check("R3 boosted after 4 edges", gainBoost, 1'b1);
    senseLowA[0] = 0;
    tick(HOLD + 1);
    check("R8 still boosted before hold ends", gainBoost, 1'b1);
    tick(1);
    check("R8 back to 1x after hold", gainBoost, 1'b0);
    // restart of the hold count
    senseLowA[0] = 1; tick(4);
    senseLowA[0] = 0; tick(3);
    senseLowA[0] = 1; tick(4);
    check("R8 reasserted flag restarts hold", gainBoost, 1'b1);
    senseLowA[0] = 0;
    tick(HOLD + 1);
    check("R8 restarted hold not yet done", gainBoost, 1'b1);
    tick(1);
    check("R8 restarted hold done", gainBoost, 1'b0);
  endtask

  task automatic t_glitch();
    senseLowA[1] = 1; tick(1);
    senseLowA[1] = 0; tick(6);
    check("R4 one-clock pulse ignored", gainBoost, 1'b0);
  endtask

  task automatic t_bank_mask();
    enBankA = 1; enBankB = 0;
    senseLowB = 3'b111; tick(6);
    check("R5 disabled bank B ignored", gainBoost, 1'b0);
    senseLowB = '0; tick(3);
    enBankA = 0; enBankC = 1;
    senseLowA = 5'b11111; tick(6);
    check("R5 disabled bank A ignored", gainBoost, 1'b0);
    check("R2 indicator bank alone keeps pump on", pumpOn, 1'b1);
    senseLowA = '0; tick(3);
    enBankC = 0; enBankA = 1; tick(1);
  endtask

  task automatic t_last_pins();
    enBankA = 1; enSenseLastA = 0; enBankB = 0;
    senseLowA[4] = 1; tick(6);
    check("R6 unsensed last A pin ignored", gainBoost, 1'b0);
    enSenseLastA = 1; tick(1);
    check("R6 last A pin sensed once enabled", gainBoost, 1'b1);
    senseLowA[4] = 0; tick(HOLD + 2);
    check("R6 return after last A pin clears", gainBoost, 1'b0);
    enBankB = 1; enLastB = 0; #1;
    check("R6 driveLastB off", driveLastB, 1'b0);
    tick(1);
    senseLowB[2] = 1; tick(6);
    check("R6 disabled last B pin ignored", gainBoost, 1'b0);
    enLastB = 1; #1;
    check("R6 driveLastB on", driveLastB, 1'b1);
    tick(1);
    check("R6 last B pin sensed once enabled", gainBoost, 1'b1);
    senseLowB[2] = 0; tick(HOLD + 2);
    check("R6 return after last B pin clears", gainBoost, 1'b0);
  endtask

  task automatic t_each_pin();
    allOn();
    for (int i = 0; i < 8; i++) begin
      setPin(i, 1'b1); tick(4);
      check($sformatf("R7 pin %0d boosts", i), gainBoost, 1'b1);
      setPin(i, 1'b0); tick(HOLD + 2);
      check($sformatf("R7 pin %0d released", i), gainBoost, 1'b0);
    end
  endtask

  task automatic t_hold_zero();
    holdCount = 8'd0;
    senseLowB[0] = 1; tick(4);
    check("R8 zero hold boosted", gainBoost, 1'b1);
    senseLowB[0] = 0; tick(2);
    check("R8 zero hold still boosted", gainBoost, 1'b1);
    tick(1);
    check("R8 zero hold acts as one", gainBoost, 1'b0);
    holdCount = 8'(HOLD);
  endtask

  task automatic t_thermal();
    senseLowA[2] = 1; tick(4);
    check("R9 boosted before trip", gainBoost, 1'b1);
    thermalTrip = 1; tick(1);
    check("R9 pump off on trip", pumpOn, 1'b0);
    check("R9 gain 1x on trip", gainBoost, 1'b0);
    tick(3);
    check("R9 pump stays off", pumpOn, 1'b0);
    thermalTrip = 0; tick(1);
    check("R9 pump back on", pumpOn, 1'b1);
    check("R9 restarts at 1x", gainBoost, 1'b0);
    tick(1);
    check("R9 boost again with flag", gainBoost, 1'b1);
    senseLowA[2] = 0; tick(HOLD + 2);
  endtask

  task automatic t_shutdown();
    senseLowA[3] = 1; tick(4);
    check("R2 boosted before shutdown", gainBoost, 1'b1);
    enBankA = 0; enBankB = 0; enBankC = 0; tick(1);
    check("R2 pump off when all banks off", pumpOn, 1'b0);
    check("R2 gain 1x when all banks off", gainBoost, 1'b0);
    tick(4);
    check("R2 stays off with flag high", gainBoost, 1'b0);
    senseLowA[3] = 0;
    enBankC = 1; tick(1);
    check("R2 indicator enable starts pump", pumpOn, 1'b1);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_boost_and_hold();
    t_glitch();
    t_bank_mask();
    t_last_pins();
    t_each_pin();
    t_hold_zero();
    t_thermal();
    t_shutdown();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule